// File: doc/BRIEF.md
# Bus-Mapped Parallel Output Port

This block is an output-only parallel port that sits on a synchronous processor bus and feeds a character-oriented device such as a printer. It watches every bus cycle, compares the upper address bits with its own base address, and, on a match, uses the two lowest address bits to pick one of its registers: an 8-bit data register that drives the device, or a status register whose bit 0 tells software whether the device can take another character.

Writing the data register latches the byte onto the device data lines and raises a valid strobe toward the device. The strobe stays up until the device signals, by a rising edge on its idle line, that it has consumed the character. While the strobe is up the status bit reads 0, and afterwards it reads 1. Each addressed bus cycle is answered by a small two-state timing machine that returns a one-cycle ready pulse, with read data presented during that pulse. Cycles to other addresses get no answer.

Top module: `pout_port`

## Requirements
- R1: After synchronous reset, bus_ack is 0, bus_rdata is 0x00, dev_data is 0x00, dev_valid is 0 and a read of the status register returns 0x01.
- R2: The port answers only a cycle with bus_req high whose bus_addr[ADDR_W-1:2] equals PORT_BASE; any other cycle gives no bus_ack and changes no register.
- R3: A matched request sampled at clock edge k gives bus_ack high for exactly the one cycle after edge k; bus_ack is low again after edge k+1.
- R4: A matched write (bus_rd = 0) with bus_addr[1:0] = 2'b00 loads bus_wdata into the data register, visible on dev_data right after the accepting edge.
- R5: That write raises dev_valid, which stays high until the first clock edge at which dev_idle is seen rising (1 now, 0 at the previous edge); a steady dev_idle level does not clear it.
- R6: A read (bus_rd = 1) with bus_addr[1:0] = 2'b01 returns status: bit 0 is 1 when dev_valid is low and 0 when it is high; bits 7 to 1 are 0.
- R7: A read with bus_addr[1:0] = 2'b00 returns the last byte written to the data register.
- R8: Select codes 2'b10 and 2'b11 read as 0x00, and writes to them are acknowledged but change nothing.
- R9: A data write has priority: a write while dev_valid is high replaces dev_data and keeps dev_valid high, and a write in the same cycle as a dev_idle rise also leaves dev_valid high.
- R10: bus_rdata is 0x00 in every cycle in which bus_ack is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Master marks an active bus cycle |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | ADDR_W | Bus address; upper bits decoded, bits 1:0 select register |
| bus_wdata | input | 8 | Write data from the master |
| bus_rdata | output | 8 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | One-cycle slave-ready pulse |
| dev_data | output | 8 | Character toward the device |
| dev_valid | output | 1 | Character is pending for the device |
| dev_idle | input | 1 | Device reports it has finished with the character (rising edge) |

## Verification
A wrong timing state shows up in the cycle after the accepting edge as a missing, doubled or unrequested bus_ack, so every bus cycle in the bench checks both the pulse cycle and the cycle after it. A wrong decode is visible at once because the bench sweeps every address and expects exactly four to answer. A stuck or early-cleared handshake flag shows on dev_valid one edge after the write or the idle rise, and again through the status bit on the next read, so each character in the data sweep is followed by both observations.

// File: rtl/pout_pkg.sv
package pout_pkg;

    localparam int DATA_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA   = 2'b00,
        SEL_STATUS = 2'b01,
        SEL_RSV2   = 2'b10,
        SEL_RSV3   = 2'b11
    } sel_t;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RESPOND = 1'b1
    } tstate_t;

    typedef struct packed {
        logic              accept;
        logic              rd;
        sel_t              sel;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    function automatic logic [DATA_W-1:0] status_byte(input logic busy);
        logic [DATA_W-1:0] s;
        s    = '0;
        s[0] = ~busy;
        return s;
    endfunction

endpackage

// File: rtl/pout_decode.sv
module pout_decode
    import pout_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-SEL_W-1:0] PORT_BASE = 6'h2A
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              go,
    output sel_t              sel
);

    logic hit;

    always_comb begin
        hit = (addr[ADDR_W-1:SEL_W] == PORT_BASE);
        go  = req & hit;
        sel = sel_t'(addr[SEL_W-1:0]);
    end

endmodule

// File: rtl/pout_timing.sv
module pout_timing
    import pout_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic accept,
    output logic ack
);

    tstate_t state_q;
    tstate_t state_d;

    always_comb begin
        accept  = go && (state_q == ST_IDLE);
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (go) state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        ack = (state_q == ST_RESPOND);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R3: acknowledge lasts one cycle
    a_r3_ack_single: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    // R3: an accepted cycle is answered on the next cycle
    a_r3_accept_acked: assert property (@(posedge clk) disable iff (rst)
        accept |=> ack);
    // R2: no answer without a decoded request
    a_r2_ack_needs_go: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(go));

endmodule

// File: rtl/pout_regs.sv
module pout_regs
    import pout_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dev_idle,
    input  sel_t              rd_sel,
    output logic [DATA_W-1:0] data_q,
    output logic              busy_q,
    output logic [DATA_W-1:0] rd_value
);

    logic idle_q;
    logic idle_rise;

    always_comb begin
        idle_rise = dev_idle & ~idle_q;
        case (rd_sel)
            SEL_DATA:   rd_value = data_q;
            SEL_STATUS: rd_value = status_byte(busy_q);
            default:    rd_value = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= 1'b0;
            data_q <= '0;
            busy_q <= 1'b0;
        end else begin
            idle_q <= dev_idle;
            if (load) begin
                data_q <= wdata;
                busy_q <= 1'b1;
            end else if (idle_rise) begin
                busy_q <= 1'b0;
            end
        end
    end

    // R4: a load takes the write data and marks the character pending
    a_r4_load_takes: assert property (@(posedge clk) disable iff (rst)
        load |=> (data_q == $past(wdata)) && busy_q);
    // R5: pending flag holds until an idle rise
    a_r5_valid_hold: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !idle_rise) |=> busy_q);
    // R5: an idle rise without a new load clears the flag
    a_r5_rise_clears: assert property (@(posedge clk) disable iff (rst)
        (idle_rise && !load) |=> !busy_q);
    // R9: data changes only on a load
    a_r9_data_only_on_load: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(data_q));

endmodule

// File: rtl/pout_port.sv
module pout_port
    import pout_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-SEL_W-1:0] PORT_BASE = 6'h2A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] dev_data,
    output logic              dev_valid,
    input  logic              dev_idle
);

    logic              go;
    sel_t              sel;
    logic              accept;
    logic              busy;
    logic [DATA_W-1:0] rd_value;
    xfer_t             xfer;
    logic              load;
    logic [DATA_W-1:0] rdata_q;

    pout_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_BASE (PORT_BASE)
    ) u_decode (
        .req  (bus_req),
        .addr (bus_addr),
        .go   (go),
        .sel  (sel)
    );

    pout_timing u_timing (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .accept (accept),
        .ack    (bus_ack)
    );

    always_comb begin
        xfer.accept = accept;
        xfer.rd     = bus_rd;
        xfer.sel    = sel;
        xfer.wdata  = bus_wdata;
        load        = xfer.accept && !xfer.rd && (xfer.sel == SEL_DATA);
    end

    pout_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .wdata    (xfer.wdata),
        .dev_idle (dev_idle),
        .rd_sel   (xfer.sel),
        .data_q   (dev_data),
        .busy_q   (busy),
        .rd_value (rd_value)
    );

    always_ff @(posedge clk) begin
        if (rst)                          rdata_q <= '0;
        else if (xfer.accept && xfer.rd)  rdata_q <= rd_value;
        else                              rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
    assign dev_valid = busy;

    // R10: read bus quiet outside the acknowledge cycle
    a_r10_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
        !bus_ack |-> (bus_rdata == '0));
    // R6: status read reports the inverted pending flag, upper bits zero
    a_r6_status_read: assert property (@(posedge clk) disable iff (rst)
        (accept && bus_rd && sel == SEL_STATUS)
        |=> (bus_rdata[DATA_W-1:1] == '0) && (bus_rdata[0] == !$past(busy)));
    // R8: reserved writes leave the data register alone
    a_r8_reserved_write: assert property (@(posedge clk) disable iff (rst)
        (accept && !bus_rd && sel[1]) |=> $stable(dev_data));
    // R2: an undecoded cycle leaves the data register alone
    a_r2_miss_no_change: assert property (@(posedge clk) disable iff (rst)
        !go |=> $stable(dev_data));

endmodule

// File: tb/pout_port_bench.sv
module pout_port_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_req;
    logic       bus_rd;
    logic [7:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       bus_ack;
    logic [7:0] dev_data;
    logic       dev_valid;
    logic       dev_idle;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_data;
    logic       m_busy;

    localparam logic [5:0] BASE = 6'h2A;

    always #5 clk = ~clk;

    pout_port #(.ADDR_W(8), .PORT_BASE(BASE)) u_pout_port (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .dev_data  (dev_data),
        .dev_valid (dev_valid),
        .dev_idle  (dev_idle)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns the ack and data seen in the pulse cycle.
    task automatic bus_op(input logic [7:0] a, input logic rd, input logic [7:0] wd,
                          output logic ackv, output logic [7:0] rdv);
        bus_addr  = a;
        bus_rd    = rd;
        bus_wdata = wd;
        bus_req   = 1'b1;
        @(negedge clk);
        ackv    = bus_ack;
        rdv     = bus_rdata;
        bus_req = 1'b0;
        @(negedge clk);
        chk("R3", "ack low after pulse", {31'd0, bus_ack}, 32'd0);
        chk("R10", "rdata quiet after pulse", {24'd0, bus_rdata}, 32'd0);
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] s);
        case (s)
            2'b00:   return m_data;
            2'b01:   return {7'd0, ~m_busy};
            default: return 8'h00;
        endcase
    endfunction

    task automatic do_write(input logic [1:0] s, input logic [7:0] v);
        logic       a;
        logic [7:0] r;
        bus_op({BASE, s}, 1'b0, v, a, r);
        chk("R3", "write acknowledged", {31'd0, a}, 32'd1);
        if (s == 2'b00) begin
            m_data = v;
            m_busy = 1'b1;
        end
    endtask

    task automatic do_read(input string req, input logic [1:0] s);
        logic       a;
        logic [7:0] r;
        bus_op({BASE, s}, 1'b1, 8'h00, a, r);
        chk("R3", "read acknowledged", {31'd0, a}, 32'd1);
        chk(req, "read value", {24'd0, r}, {24'd0, exp_read(s)});
    endtask

    task automatic idle_pulse;
        dev_idle = 1'b1;
        @(negedge clk);
        m_busy = 1'b0;
        chk("R5", "valid cleared by idle rise", {31'd0, dev_valid}, 32'd0);
        dev_idle = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; bus_req = 1'b0; bus_rd = 1'b0; bus_addr = '0;
        bus_wdata = '0; dev_idle = 1'b0;
        m_data = 8'h00; m_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1", "ack after reset", {31'd0, bus_ack}, 32'd0);
        chk("R1", "rdata after reset", {24'd0, bus_rdata}, 32'd0);
        chk("R1", "dev_data after reset", {24'd0, dev_data}, 32'd0);
        chk("R1", "dev_valid after reset", {31'd0, dev_valid}, 32'd0);
        do_read("R1", 2'b01);

        // R2 R8: exhaustive address sweep with reads
        for (int i = 0; i < 256; i++) begin
            logic       a;
            logic [7:0] r;
            logic [7:0] ad;
            logic       hit;
            ad  = 8'(i);
            hit = (ad[7:2] == BASE);
            bus_op(ad, 1'b1, 8'h00, a, r);
            chk("R2", "answer only on own address", {31'd0, a}, {31'd0, hit});
            chk(ad[1] ? "R8" : "R6", "swept read",
                {24'd0, r}, hit ? {24'd0, exp_read(ad[1:0])} : 32'd0);
        end

        // R4 R5 R6 R7 R8 R2: every data value
        for (int v = 0; v < 256; v++) begin
            logic       a;
            logic [7:0] r;
            logic [7:0] val;
            val = 8'(v);
            do_write(2'b00, val);
            chk("R4", "dev_data loaded", {24'd0, dev_data}, {24'd0, val});
            chk("R5", "dev_valid raised", {31'd0, dev_valid}, 32'd1);
            do_read("R6", 2'b01);
            do_read("R7", 2'b00);
            do_write({1'b1, val[0]}, ~val);
            chk("R8", "reserved write ignored", {24'd0, dev_data}, {24'd0, val});
            bus_op({~BASE, 2'b00}, 1'b0, val ^ 8'h5A, a, r);
            chk("R2", "foreign write unanswered", {31'd0, a}, 32'd0);
            chk("R2", "foreign write ignored", {24'd0, dev_data}, {24'd0, val});
            chk("R5", "valid still pending", {31'd0, dev_valid}, 32'd1);
            idle_pulse();
            do_read("R6", 2'b01);
        end

        // R5: long wait with idle low keeps valid
        do_write(2'b00, 8'h3C);
        repeat (20) @(negedge clk);
        chk("R5", "valid held while idle low", {31'd0, dev_valid}, 32'd1);

        // R9: overwrite while pending
        do_write(2'b00, 8'hC3);
        chk("R9", "overwrite data", {24'd0, dev_data}, 32'hC3);
        chk("R9", "overwrite keeps valid", {31'd0, dev_valid}, 32'd1);

        // R9: write in the same cycle as an idle rise
        bus_addr = {BASE, 2'b00}; bus_rd = 1'b0; bus_wdata = 8'h99;
        bus_req = 1'b1; dev_idle = 1'b1;
        @(negedge clk);
        bus_req = 1'b0;
        m_data = 8'h99; m_busy = 1'b1;
        chk("R9", "write wins over idle rise", {31'd0, dev_valid}, 32'd1);
        chk("R9", "coincident write data", {24'd0, dev_data}, 32'h99);
        // R5: steady high idle does not clear
        repeat (10) @(negedge clk);
        chk("R5", "steady idle does not clear", {31'd0, dev_valid}, 32'd1);
        do_read("R6", 2'b01);
        dev_idle = 1'b0;
        @(negedge clk);
        idle_pulse();
        do_read("R6", 2'b01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R3 bus sequence actual=timeout expected=complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule